// File: doc/BRIEF.md
# Low-Speed Time-Base Divider

The block divides a 32.768 kHz low-speed clock with a 15-bit binary counter that runs freely from reset. Twelve of the counter's bits are brought out as square waves, from 2048 Hz down to 1 Hz. Software or neighbouring logic can read these levels at any time. Four of the slower taps also raise periodic interrupt requests: one at 32 Hz, one at 16 Hz, one at 4 Hz and one at 2 Hz. Each request has its own enable bit. The least significant counter bit is also brought out as the halved clock, which is the base for the serial port's baud selection.

A synchronous clear input zeroes the whole counter, so every tap restarts in phase. Software uses it to align periodic events to a known instant. The block has no data stream, so every pin is a plain level or pulse signal.

Top module: `tbd_timebase`

## Requirements
- R1: While rst_ni is low, tap_o, irq_o and baud_half_o are all zero.
- R2: The count advances by one on every clock edge and wraps from 32767 to 0. tap_o[j] equals count bit j+3. This makes tap_o[0] a 2048 Hz square wave and tap_o[11] a 1 Hz square wave at a 32.768 kHz clock.
- R3: A tap rises only in a cycle where every lower tap is low, as in a binary carry chain.
- R4: irq_o[0], irq_o[1], irq_o[2] and irq_o[3] follow count bits 9, 10, 12 and 13, which are tap_o[6], tap_o[7], tap_o[9] and tap_o[10] (32, 16, 4 and 2 Hz). Each pulse lasts one cycle and occurs in the cycle in which its tap has just fallen.
- R5: irq_o[i] pulses only if irq_en_i[i] was high at the clock edge on which its tap fell. The enable has no effect on tap_o.
- R6: When clr_i is high at a clock edge, the count becomes zero at that edge, and this overrides the increment.
- R7: A tap that falls because of clr_i raises no interrupt.
- R8: baud_half_o equals count bit 0, which is half the input clock rate.
- R9: On the wrap from 32767 to 0, all four enabled interrupts pulse in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Low-speed clock, 32.768 kHz |
| rst_ni | input | 1 | Asynchronous reset, active low |
| clr_i | input | 1 | Synchronous clear of the counter |
| irq_en_i | input | 4 | Enable for each interrupt source |
| tap_o | output | 12 | Tap levels; bit 0 is 2048 Hz, bit 11 is 1 Hz |
| irq_o | output | 4 | One-cycle interrupt pulses at 32, 16, 4 and 2 Hz |
| baud_half_o | output | 1 | Halved clock used as the baud base |

## Verification
The bench runs through a full 15-bit wrap, so the 1 Hz tap and the 2 Hz interrupt both fall at least once. It also runs through the wrap cycle, where all four interrupts coincide. A design that detected edges one cycle late, or that missed coincident falls, would show irq_o shifted against the model or missing. The bench pulses clr_i while the slow taps are high. A design that treated a fall caused by the clear as a real edge would then emit a spurious interrupt. The bench also changes the enable mask in the cycle just before a fall, which catches an enable that is sampled a cycle early or late.

// File: rtl/tbd_pkg.sv
package tbd_pkg;
  localparam int CNT_W  = 15;
  localparam int TAP_LO = 3;
  localparam int TAP_N  = 12;
  localparam int IRQ_N  = 4;

  // Count bit driving each interrupt source (32, 16, 4, 2 Hz).
  function automatic int irq_bit(input int idx);
    case (idx)
      0:       return 9;
      1:       return 10;
      2:       return 12;
      default: return 13;
    endcase
  endfunction
endpackage

// File: rtl/tbd_counter.sv
module tbd_counter #(
  parameter int W = 15
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    cnt_o <= '0;
    else if (clr_i) cnt_o <= '0;
    else            cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/tbd_fall_pulse.sv
module tbd_fall_pulse #(
  parameter int BIT = 9
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         en_i,
  input  logic [BIT:0] low_i,
  output logic         irq_o
);
  // Bit BIT falls at the next edge exactly when the low bits are all ones.
  logic fall_next;
  assign fall_next = &low_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) irq_o <= 1'b0;
    else         irq_o <= fall_next & en_i & ~clr_i;
  end
endmodule

// File: rtl/tbd_timebase.sv
module tbd_timebase
  import tbd_pkg::*;
#(
  parameter int CW   = CNT_W,
  parameter int TLO  = TAP_LO,
  parameter int NTAP = TAP_N,
  parameter int NIRQ = IRQ_N
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            clr_i,
  input  logic [NIRQ-1:0] irq_en_i,
  output logic [NTAP-1:0] tap_o,
  output logic [NIRQ-1:0] irq_o,
  output logic            baud_half_o
);
  logic [CW-1:0] cnt;

  tbd_counter #(.W(CW)) u_cnt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (clr_i),
    .cnt_o  (cnt)
  );

  for (genvar j = 0; j < NTAP; j++) begin : g_tap
    assign tap_o[j] = cnt[TLO + j];
  end

  assign baud_half_o = cnt[0];

  for (genvar i = 0; i < NIRQ; i++) begin : g_irq
    localparam int B = irq_bit(i);
    tbd_fall_pulse #(.BIT(B)) u_fall (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (clr_i),
      .en_i   (irq_en_i[i]),
      .low_i  (cnt[B:0]),
      .irq_o  (irq_o[i])
    );
  end
endmodule

// File: rtl/tbd_timebase_chk.sv
module tbd_timebase_chk
  import tbd_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              clr_i,
  input logic [IRQ_N-1:0]  irq_en_i,
  input logic [TAP_N-1:0]  tap_o,
  input logic [IRQ_N-1:0]  irq_o,
  input logic              baud_half_o
);
  AST_CLR_ZEROES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (tap_o == '0 && !baud_half_o)); // R6

  for (genvar i = 0; i < IRQ_N; i++) begin : g_irq_chk
    localparam int T = irq_bit(i) - TAP_LO;
    AST_IRQ_ON_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> $fell(tap_o[T])); // R4
    AST_IRQ_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |=> !irq_o[i]); // R4
    AST_IRQ_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> $past(irq_en_i[i])); // R5
    AST_IRQ_NOT_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
      irq_o[i] |-> !$past(clr_i)); // R7
  end

  for (genvar j = 1; j < TAP_N; j++) begin : g_carry_chk
    AST_CARRY_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(tap_o[j]) |-> (tap_o[j-1] == 1'b0)); // R3
  end
endmodule

bind tbd_timebase tbd_timebase_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .clr_i       (clr_i),
  .irq_en_i    (irq_en_i),
  .tap_o       (tap_o),
  .irq_o       (irq_o),
  .baud_half_o (baud_half_o)
);

// File: tb/sim_tbd_timebase.sv
module sim_tbd_timebase;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        clr = 1'b0;
  logic [3:0]  en = 4'h0;
  logic [11:0] tap;
  logic [3:0]  irq;
  logic        baud;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct packed {
    logic [11:0] tap;
    logic [3:0]  irq;
    logic        baud;
  } exp_t;

  exp_t sb_q[$];
  int   model_cnt = 0;
  int   irq_bits[4] = '{9, 10, 12, 13};
  bit   done = 1'b0;

  always #2 clk = ~clk;

  tbd_timebase u0 (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .clr_i       (clr),
    .irq_en_i    (en),
    .tap_o       (tap),
    .irq_o       (irq),
    .baud_half_o (baud)
  );

  // Driver: apply inputs, predict the result of the coming edge, push it.
  task automatic step(input logic c, input logic [3:0] e);
    exp_t x;
    clr = c;
    en  = e;
    for (int i = 0; i < 4; i++) begin
      int m = (1 << (irq_bits[i] + 1)) - 1;
      x.irq[i] = e[i] && !c && ((model_cnt & m) == m);   // R4 R5 R7 R9
    end
    model_cnt = c ? 0 : ((model_cnt + 1) & 32'h7FFF);   // R2 R6
    x.tap  = 12'((model_cnt >> 3) & 12'hFFF);
    x.baud = model_cnt[0];                               // R8
    sb_q.push_back(x);
    @(negedge clk);
  endtask

  // Monitor: compare just after each edge.
  always @(posedge clk) begin
    #1;
    if (rst_n && sb_q.size() > 0) begin
      exp_t x;
      x = sb_q.pop_front();
      n_chk++;
      if (tap !== x.tap) begin
        n_bad++;
        $display("FAIL R2/R3/R6 tap: got %h exp %h", tap, x.tap);
      end
      if (irq !== x.irq) begin
        n_bad++;
        $display("FAIL R4/R5/R7/R9 irq: got %b exp %b", irq, x.irq);
      end
      if (baud !== x.baud) begin
        n_bad++;
        $display("FAIL R8 baud: got %b exp %b", baud, x.baud);
      end
    end
  end

  initial begin
    #700000;
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    n_chk++;
    if (tap !== 12'h0 || irq !== 4'h0 || baud !== 1'b0) begin
      n_bad++;
      $display("FAIL R1 reset: got tap %h irq %b baud %b exp 0 0 0", tap, irq, baud);
    end
    rst_n = 1'b1;
    // Full wrap with all enables: R2 R3 R4 R8 R9.
    for (int k = 0; k < 33000; k++) step(1'b0, 4'hF);
    // Clear while slow taps are high: R6 R7.
    while (model_cnt != 12000) step(1'b0, 4'hF);
    step(1'b1, 4'hF);
    // Partial mask, R5: only 32 Hz and 4 Hz enabled.
    for (int k = 0; k < 17000; k++) step(1'b0, 4'b0101);
    // Enable toggled only in the cycle just before a 32 Hz fall, R5.
    for (int k = 0; k < 3000; k++) begin
      logic [3:0] e;
      e = ((model_cnt & 1023) == 1023) ? 4'b0001 : 4'b0000;
      step(1'b0, e);
    end
    // Clear held for several cycles, then run out past the next wrap: R6 R9.
    for (int k = 0; k < 4; k++) step(1'b1, 4'hF);
    for (int k = 0; k < 33000; k++) step(1'b0, 4'hF);
    @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule